// File: doc/BRIEF.md
# Write-Through Set-Associative Cache with RAM Mode

The block sits between a CPU and main memory. It holds 4 KB of data in 64 sets of four ways with 16-byte lines. A CPU read that finds its line returns data without touching memory. A read that misses fetches the whole line as a four-word burst and then answers. Every CPU write is forwarded to memory. A write that hits also updates the cached copy. A write that misses leaves the cache unchanged. When a set is full, the line that was used least recently is replaced.

A configuration input turns the upper two ways into 2 KB of directly addressed local RAM. While that input is set, the cache keeps working with the two lower ways only. CPU accesses that fall inside a fixed address window then read and write the upper two ways' data storage directly, with no memory traffic. A single-cycle invalidate input discards every cached line.

The CPU port uses a request held until a one-cycle ready pulse. The memory port uses a request held until acknowledged. A write takes one acknowledge. A line fill takes four acknowledges, each carrying one word in ascending order.

Top module: `wt_cache`

## Requirements
- R1: A read miss issues one read burst on the memory port at the line-aligned address (offset bits [3:0] zero) and holds the request until four words have been acknowledged. The block stores the four words as the line. Ready then pulses for one cycle, with the requested word (selected by address bits [3:2]) on the read data output.
- R2: A read that hits answers with ready in the cycle after it is accepted. It makes no memory request and returns the most recent value written to that address.
- R3: Every CPU write outside the RAM window produces exactly one memory write of the same word-aligned address and data. Ready pulses after the acknowledge. A write hit updates the cached word. A write miss allocates no line, so a later read of that address misses and returns the written data.
- R4: On a miss, the line is placed in the lowest-numbered eligible invalid way. If every eligible way is valid, it replaces the eligible way used least recently, where both hits and fills count as use. At most one way hits.
- R5: Address bits [9:4] select the set and bits [31:10] form the tag. Lines whose addresses differ only in the tag compete for the same set.
- R6: With RAM mode set, word accesses with address bits [31:11] equal to those of RAM_BASE (default 0xFFFFF800) go to local RAM. Bit 10 selects way 2 (0) or way 3 (1), bits [9:4] the set and bits [3:2] the word. Such accesses answer in the cycle after acceptance, make no memory request, and reads return the last value written.
- R7: With RAM mode set, lookup and replacement use only ways 0 and 1, so a third distinct line in a set evicts the older of the two.
- R8: While RAM mode is set, ways 2 and 3 hold no valid line. Lines they held before RAM mode was entered miss after it is left.
- R9: A one-cycle pulse on the invalidate input makes every line invalid from the next cycle on.
- R10: After reset, ready and the memory request are low and all lines are invalid.
- R11: With RAM mode clear, addresses in the RAM window are ordinary cacheable memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_mode | input | 1 | 1: upper two ways act as local RAM |
| inv_all | input | 1 | Invalidate all lines |
| cpu_req | input | 1 | CPU request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with ready |
| mem_req | output | 1 | Memory request, held until done |
| mem_we | output | 1 | 1 = memory write, 0 = line read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one per word |
| mem_rdata | input | 32 | Line fill word, valid with acknowledge |

## Verification
The assertions assume a well-behaved environment. The CPU keeps address, data and direction stable from request until ready. The configuration and invalidate inputs change only while no CPU request is outstanding. The memory answers a read with exactly four acknowledges and a write with exactly one. The bench drives requests only through a task that waits for ready before dropping them. It changes RAM mode and pulses invalidate only between transactions, and its memory model counts acknowledges to those fixed numbers. Under those conditions the pass-through checks are valid: hits are one-hot, the victim stays in the lower ways in RAM mode, and the upper ways stay empty.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } wtc_state_e;

  // position of the order bit for way pair (i, j), i < j
  function automatic int pair_idx(input int i, input int j, input int ways);
    return i * ways - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/wtc_lru.sv
module wtc_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PAIRS = WAYS * (WAYS - 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WAYS-1:0]  elig,
  input  logic [WAYS-1:0]  valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way
);
  import wtc_pkg::*;

  // bit (i,j) set: way i used more recently than way j
  logic [PAIRS-1:0] ord_q [SETS];
  logic [PAIRS-1:0] ord_nxt;
  logic [PAIRS-1:0] cur;
  logic [WAYS-1:0]  old_vec;
  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    ord_nxt = ord_q[touch_idx];
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (touch_way == WAY_W'(i))      ord_nxt[pair_idx(i, j, WAYS)] = 1'b1;
        else if (touch_way == WAY_W'(j)) ord_nxt[pair_idx(i, j, WAYS)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ord_q[s] <= '0;
    end else if (touch_en) begin
      ord_q[touch_idx] <= ord_nxt;
    end
  end

  always_comb begin
    cur        = ord_q[rd_idx];
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (elig[w] && !valid[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      old_vec[w] = elig[w];
      for (int o = 0; o < WAYS; o++) begin
        if (o != w && elig[o]) begin
          if (w < o) begin
            if (cur[pair_idx(w, o, WAYS)]) old_vec[w] = 1'b0;
          end else begin
            if (!cur[pair_idx(o, w, WAYS)]) old_vec[w] = 1'b0;
          end
        end
      end
    end
    old_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (old_vec[w]) old_way = WAY_W'(w);
    end
    victim = free_found ? free_way : old_way;
  end

endmodule

// File: rtl/wtc_tags.sv
module wtc_tags #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W    = $clog2(SETS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int RAM_WAYS = WAYS / 2,
  localparam logic [WAYS-1:0] LOW_MASK = WAYS'((1 << (WAYS - RAM_WAYS)) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ram_mode,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [WAYS-1:0]  elig,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_d[s] = valid_q[s];
      if (inv_all)  valid_d[s] = '0;
      if (ram_mode) valid_d[s] = valid_d[s] & LOW_MASK;
      if (fill_en && fill_idx == IDX_W'(s)) valid_d[s][fill_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
  end

  assign valid_vec = valid_q[lk_idx];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = elig[w] && valid_vec[w] && (tag_q[lk_idx][w] == lk_tag);
    end
  endgenerate

endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          SETS       = 64,
  parameter int          WAYS       = 4,
  parameter int          LINE_BYTES = 16,
  parameter logic [31:0] RAM_BASE   = 32'hFFFF_F800,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int WORDS      = LINE_BYTES / WORD_BYTES,
  localparam int BSEL_W     = $clog2(WORD_BYTES),
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int WSEL_W     = $clog2(WORDS),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - IDX_W - OFS_W,
  localparam int WAY_W      = $clog2(WAYS),
  localparam int RAM_WAYS   = WAYS / 2,
  localparam int RSEL_W     = (RAM_WAYS > 1) ? $clog2(RAM_WAYS) : 1,
  localparam int WIN_LSB    = $clog2(RAM_WAYS * SETS * LINE_BYTES),
  localparam int DEPTH      = WAYS * SETS * WORDS,
  localparam int DAW        = WAY_W + IDX_W + WSEL_W,
  localparam logic [WAYS-1:0] LOW_MASK = WAYS'((1 << (WAYS - RAM_WAYS)) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_mode,
  input  logic              inv_all,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wtc_pkg::*;

  wtc_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  vict_q;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [IDX_W-1:0]  req_idx, q_idx;
  logic [WSEL_W-1:0] req_wsel, q_wsel;
  logic [TAG_W-1:0]  req_tag, q_tag;
  logic [RSEL_W-1:0] ram_sel;
  logic              in_win;
  logic [WAY_W-1:0]  ram_way;
  logic [WAYS-1:0]   elig;
  logic [WAYS-1:0]   lk_hit, lk_valid;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  lru_victim;
  logic              accept;

  logic              d_we;
  logic [WAY_W-1:0]  d_way, rd_way;
  logic [IDX_W-1:0]  d_idx;
  logic [WSEL_W-1:0] d_word;
  logic [DATA_W-1:0] d_wdata, d_rdata;
  logic              touch_en;
  logic [WAY_W-1:0]  touch_way;
  logic [IDX_W-1:0]  touch_idx;
  logic              fill_en;
  logic              unused_bits;

  // address fields
  assign req_idx  = cpu_addr[OFS_W+IDX_W-1:OFS_W];
  assign req_wsel = cpu_addr[OFS_W-1:BSEL_W];
  assign req_tag  = cpu_addr[ADDR_W-1:OFS_W+IDX_W];
  assign q_idx    = addr_q[OFS_W+IDX_W-1:OFS_W];
  assign q_wsel   = addr_q[OFS_W-1:BSEL_W];
  assign q_tag    = addr_q[ADDR_W-1:OFS_W+IDX_W];
  assign ram_sel  = cpu_addr[WIN_LSB-1 -: RSEL_W];
  assign in_win   = ram_mode && (cpu_addr[ADDR_W-1:WIN_LSB] == RAM_BASE[ADDR_W-1:WIN_LSB]);
  assign ram_way  = WAY_W'(WAYS - RAM_WAYS) + WAY_W'(ram_sel);
  assign elig     = ram_mode ? LOW_MASK : {WAYS{1'b1}};
  assign accept   = (state_q == ST_IDLE) && cpu_req;
  assign unused_bits = ^{cpu_addr[BSEL_W-1:0], addr_q[BSEL_W-1:0]};

  assign hit = |lk_hit;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit[w]) hit_way = WAY_W'(w);
    end
  end

  wtc_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ram_mode (ram_mode),
    .inv_all  (inv_all),
    .lk_idx   (req_idx),
    .lk_tag   (req_tag),
    .elig     (elig),
    .hit_vec  (lk_hit),
    .valid_vec(lk_valid),
    .fill_en  (fill_en),
    .fill_idx (q_idx),
    .fill_way (vict_q),
    .fill_tag (q_tag)
  );

  wtc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .elig     (elig),
    .valid    (lk_valid),
    .victim   (lru_victim),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .touch_way(touch_way)
  );

  assign rd_way = in_win ? ram_way : hit_way;

  wtc_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk  (clk),
    .we   (d_we),
    .waddr(DAW'({d_way, d_idx, d_word})),
    .wdata(d_wdata),
    .raddr(DAW'({rd_way, req_idx, req_wsel})),
    .rdata(d_rdata)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    rdata_d   = rdata_q;
    beat_d    = beat_q;
    d_we      = 1'b0;
    d_way     = in_win ? ram_way : hit_way;
    d_idx     = req_idx;
    d_word    = req_wsel;
    d_wdata   = cpu_wdata;
    touch_en  = 1'b0;
    touch_way = hit_way;
    touch_idx = req_idx;
    fill_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (in_win) begin
            d_we    = cpu_we;
            rdata_d = d_rdata;
            state_d = ST_DONE;
          end else if (!cpu_we) begin
            if (hit) begin
              rdata_d  = d_rdata;
              touch_en = 1'b1;
              state_d  = ST_DONE;
            end else begin
              beat_d  = '0;
              state_d = ST_FILL;
            end
          end else begin
            d_we     = hit;
            touch_en = hit;
            state_d  = ST_WRITE;
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          d_we    = 1'b1;
          d_way   = vict_q;
          d_idx   = q_idx;
          d_word  = beat_q;
          d_wdata = mem_rdata;
          if (beat_q == q_wsel) rdata_d = mem_rdata;
          beat_d = beat_q + 1'b1;
          if (beat_q == {WSEL_W{1'b1}}) begin
            fill_en   = 1'b1;
            touch_en  = 1'b1;
            touch_way = vict_q;
            touch_idx = q_idx;
            state_d   = ST_DONE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      vict_q  <= lru_victim;
    end
  end

  always_ff @(posedge clk) begin
    beat_q  <= beat_d;
    rdata_q <= rdata_d;
  end

  assign cpu_ready = (state_q == ST_DONE);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
                                          : {addr_q[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          WAYS    = 4,
  parameter int          WIN_LSB = 11,
  parameter logic [31:0] RAM_BASE = 32'hFFFF_F800,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LOW_N = WAYS - WAYS / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_mode,
  input logic              inv_all,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [WAYS-1:0]   hit_vec,
  input logic [WAYS-1:0]   valid_vec,
  input logic [WAY_W-1:0]  victim,
  input logic              fill_en
);

  logic win;
  assign win = ram_mode && (cpu_addr[ADDR_W-1:WIN_LSB] == RAM_BASE[ADDR_W-1:WIN_LSB]);

  // R1
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R1
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[3:0] == 4'h0));

  // R1
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_ack) |=> (mem_req && !mem_we && $stable(mem_addr)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  // R4
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  ram_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && win && !cpu_ready && !mem_req) |=> !mem_req);

  // R7
  ram_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_mode |-> (victim < WAY_W'(LOW_N)));

  // R8
  ram_ways_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mode && $past(ram_mode)) |-> ((valid_vec >> LOW_N) == '0));

  // R9
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_en) |=> (valid_vec == '0));

endmodule

bind wt_cache wtc_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WAYS    (WAYS),
  .WIN_LSB (WIN_LSB),
  .RAM_BASE(RAM_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ram_mode (ram_mode),
  .inv_all  (inv_all),
  .cpu_req  (cpu_req),
  .cpu_addr (cpu_addr),
  .cpu_ready(cpu_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .hit_vec  (lk_hit),
  .valid_vec(lk_valid),
  .victim   (lru_victim),
  .fill_en  (fill_en)
);

// File: tb/wt_cache_tb.sv
module wt_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_mode, inv_all;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wt_cache u_dut (
    .clk(clk), .rst_n(rst_n), .ram_mode(ram_mode), .inv_all(inv_all),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int idle_bad = 0;
  bit busy = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem_m [int];
  logic [31:0] ex_m  [int];
  int mwait = 0, mbeat = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_ra, last_wa, last_wd;

  function automatic logic [31:0] dflt(input int wa);
    return (32'(wa) * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction
  function automatic logic [31:0] mval(input int wa);
    return mem_m.exists(wa) ? mem_m[wa] : dflt(wa);
  endfunction
  function automatic logic [31:0] exval(input int wa);
    return ex_m.exists(wa) ? ex_m[wa] : dflt(wa);
  endfunction

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (!rst_n || !mem_req) begin
      mwait = 0;
      mbeat = 0;
    end else if (mwait < MEM_LAT) begin
      mwait++;
    end else begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem_m[int'(mem_addr >> 2)] = mem_wdata;
        wr_cnt++;
        last_wa = mem_addr;
        last_wd = mem_wdata;
      end else begin
        if (mbeat == 0) begin
          rd_cnt++;
          last_ra = mem_addr;
        end
        mem_rdata = mval(int'(mem_addr >> 2) + mbeat);
        mbeat++;
      end
    end
    if (rst_n && !busy && (cpu_ready || mem_req)) idle_bad++;
  end

  // ---------------- cache reference model ----------------
  bit          mv [64][4];
  logic [21:0] mt [64][4];
  int          ordr [64][4];   // index 0 = most recent
  bit          rmode = 0;
  logic [31:0] ram_m [512];

  function automatic int mlookup(input int idx, input logic [21:0] tg);
    for (int w = 0; w < (rmode ? 2 : 4); w++)
      if (mv[idx][w] && mt[idx][w] == tg) return w;
    return -1;
  endfunction

  function automatic void mtouch(input int idx, input int w);
    int p = 0;
    for (int k = 0; k < 4; k++) if (ordr[idx][k] == w) p = k;
    for (int k = p; k > 0; k--) ordr[idx][k] = ordr[idx][k-1];
    ordr[idx][0] = w;
  endfunction

  function automatic int mvictim(input int idx);
    int n = rmode ? 2 : 4;
    int best = 0, bestpos = -1;
    for (int w = 0; w < n; w++) if (!mv[idx][w]) return w;
    for (int w = 0; w < n; w++)
      for (int k = 0; k < 4; k++)
        if (ordr[idx][k] == w && k > bestpos) begin best = w; bestpos = k; end
    return best;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tg, input int set, input int word);
    return {tg[21:0], set[5:0], word[1:0], 2'b00};
  endfunction

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       input string rq);
    int idx = int'(a[9:4]);
    logic [21:0] tg = a[31:10];
    bit win = rmode && (a[31:11] == 21'h1F_FFFF);
    int lat, w, exp_rd = 0, exp_wr = 0, rd0, wr0, bad = 0, ri;
    logic [31:0] expd = '0;
    if (win) begin
      lat = 1;
      ri = int'({a[10], a[9:4], a[3:2]});
      if (we) ram_m[ri] = wd; else expd = ram_m[ri];
    end else if (!we) begin
      w = mlookup(idx, tg);
      if (w >= 0) begin
        lat = 1;
        mtouch(idx, w);
      end else begin
        w = mvictim(idx);
        mv[idx][w] = 1'b1;
        mt[idx][w] = tg;
        mtouch(idx, w);
        lat = MEM_LAT + 5;
        exp_rd = 1;
      end
      expd = exval(int'(a >> 2));
    end else begin
      w = mlookup(idx, tg);
      if (w >= 0) mtouch(idx, w);
      lat = MEM_LAT + 2;
      exp_wr = 1;
      ex_m[int'(a >> 2)] = wd;
    end
    @(negedge clk);
    busy = 1;
    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (cpu_ready !== (c == lat)) bad++;
    end
    cpu_req = 1'b0;
    chk(bad == 0, rq, "ready cycle", 32'(bad), 32'd0);
    if (!we) chk(cpu_rdata === expd, rq, "read data", cpu_rdata, expd);
    chk(rd_cnt - rd0 == exp_rd, rq, "line fills", 32'(rd_cnt - rd0), 32'(exp_rd));
    chk(wr_cnt - wr0 == exp_wr, rq, "memory writes", 32'(wr_cnt - wr0), 32'(exp_wr));
    if (exp_rd != 0) chk(last_ra === {a[31:4], 4'h0}, rq, "fill address", last_ra, {a[31:4], 4'h0});
    if (exp_wr != 0) begin
      chk(last_wa === {a[31:2], 2'b00}, rq, "write address", last_wa, {a[31:2], 2'b00});
      chk(last_wd === wd, rq, "write data", last_wd, wd);
    end
    @(negedge clk);
    busy = 0;
  endtask

  task automatic set_rmode(input bit v);
    @(negedge clk);
    ram_mode = v;
    rmode = v;
    if (v) for (int s = 0; s < 64; s++) begin mv[s][2] = 0; mv[s][3] = 0; end
  endtask

  task automatic do_inv();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
  endtask

  task automatic finish_run();
    chk(idle_bad == 0, "R10", "idle activity", 32'(idle_bad), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf = 32'hACE1_2468;
    for (int s = 0; s < 64; s++) for (int k = 0; k < 4; k++) begin
      ordr[s][k] = 3 - k;
      mv[s][k] = 0;
    end
    rst_n = 0; ram_mode = 0; inv_all = 0; cpu_req = 0; cpu_we = 0;
    cpu_addr = '0; cpu_wdata = '0; mem_ack = 0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(cpu_ready === 1'b0, "R10", "ready after reset", 32'(cpu_ready), 32'd0);
    chk(mem_req === 1'b0, "R10", "mem_req after reset", 32'(mem_req), 32'd0);

    // R1 miss then R2 hits
    do_op(0, mk(100, 4, 1), '0, "R1");
    do_op(0, mk(100, 4, 1), '0, "R2");
    do_op(0, mk(100, 4, 3), '0, "R2");
    // R3 write hit and write miss
    do_op(1, mk(100, 4, 2), 32'hDEAD_0001, "R3");
    do_op(0, mk(100, 4, 2), '0, "R3");
    do_op(1, mk(200, 8, 0), 32'hBEEF_0002, "R3");
    do_op(0, mk(200, 8, 0), '0, "R3");
    // R4 / R5 replacement in one set
    for (int t = 0; t < 4; t++) do_op(0, mk(10 + t, 6, 0), '0, "R5");
    do_op(0, mk(10, 6, 1), '0, "R4");
    do_op(0, mk(14, 6, 0), '0, "R4");
    do_op(0, mk(10, 6, 0), '0, "R4");
    do_op(0, mk(11, 6, 0), '0, "R4");
    // R11 window is plain memory outside RAM mode
    do_op(0, 32'hFFFF_F810, '0, "R11");
    do_op(0, 32'hFFFF_F810, '0, "R11");
    // set 12 fully cached before RAM mode (for R8)
    for (int t = 0; t < 4; t++) do_op(0, mk(40 + t, 12, 0), '0, "R8");
    // R6 local RAM
    set_rmode(1);
    do_op(1, 32'hFFFF_F810, 32'h1111_2222, "R6");
    do_op(1, 32'hFFFF_FC10, 32'h3333_4444, "R6");
    do_op(0, 32'hFFFF_F810, '0, "R6");
    do_op(0, 32'hFFFF_FC10, '0, "R6");
    do_op(1, 32'hFFFF_FFFC, 32'h5555_6666, "R6");
    do_op(0, 32'hFFFF_FFFC, '0, "R6");
    // R7 two-way replacement
    do_op(0, mk(60, 9, 0), '0, "R7");
    do_op(0, mk(61, 9, 0), '0, "R7");
    do_op(0, mk(62, 9, 0), '0, "R7");
    do_op(0, mk(60, 9, 0), '0, "R7");
    do_op(0, mk(62, 9, 0), '0, "R7");
    set_rmode(0);
    // R8 lines from ways 2/3 are gone
    for (int t = 0; t < 4; t++) do_op(0, mk(40 + t, 12, 0), '0, "R8");
    // R9 invalidate
    do_op(0, mk(100, 4, 1), '0, "R9");
    do_inv();
    do_op(0, mk(100, 4, 1), '0, "R9");
    do_op(0, mk(10, 6, 0), '0, "R9");

    // mixed traffic, cache mode then RAM mode
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) set_rmode(1);
      for (int n = 0; n < 150; n++) begin
        logic [31:0] a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (ph == 1 && lf[9:8] == 2'b00)
          a = {21'h1F_FFFF, lf[4], lf[12:10], lf[21:20], lf[6:5], 2'b00};
        else
          a = mk(300 + int'(lf[2:0] % 6), lf[3] ? 3 : 5, int'(lf[6:5]));
        do_op(lf[7], a, lf ^ 32'h0F0F_0F0F, lf[7] ? "R3" : "R4");
      end
    end
    set_rmode(0);
    finish_run();
  end

endmodule